// File: doc/BRIEF.md
# FPGA Configuration Word Loader

This controller links a 16-bit host register port to the serial configuration pins of an FPGA. The host first requests a program pulse. The loader drives the target's active-low program line for a fixed number of cycles. It then waits until the target raises its INIT line. After that it reports that it can take a word. Each configuration word the host writes is sent to the target one bit at a time, most significant bit first, on a configuration clock that the loader derives from the system clock.

The host reads a single status word. Bit 1 mirrors the synchronized INIT line and bit 2 means the loader can take another word. Bit 3 is a sticky error, set when a word was taken while INIT was low. Bit 4 mirrors the synchronized DONE line. Bit 5 is set once the sync word 0xFF20 has been taken. Bits 15:12 hold a fixed version nibble, 0x5. The host writes a word only while bit 2 is set, and afterwards it checks that bit 1 is still high. The first byte of each byte pair goes in bits 15:8.

Top module: `cfg_loader`

## Requirements
- R1: After reset, cfg_prog_no is high, cfg_cclk_o is low and status bits 2, 3 and 5 read 0. The loader takes no word until a program pulse has completed and INIT has been seen high.
- R2: A high prog_i sampled on a clock edge drives cfg_prog_no low for exactly PROG_CYCLES cycles, starting at that edge. It aborts any transfer in progress, which returns cfg_cclk_o low and clears status bit 2.
- R3: Status bit 1 follows cfg_init_i after SYNC_STAGES clock edges. Once the program pulse has ended, status bit 2 rises one edge after the synchronized INIT is seen high. Bit 2 stays 0 while cfg_prog_no is low.
- R4: A taken word is sent MSB-first on cfg_din_o. Each bit is held for CLK_DIV cycles with cfg_cclk_o low, then CLK_DIV cycles with cfg_cclk_o high. cfg_din_o changes only while cfg_cclk_o is low, so the target samples it on the rising edge of cfg_cclk_o. cfg_cclk_o is low whenever status bit 2 is set.
- R5: A write taken at a clock edge holds status bit 2 low for exactly 2*CLK_DIV*WORD_W cycles, starting at that edge.
- R6: A write while status bit 2 is low is ignored: no bit is emitted and a transfer already running is not changed.
- R7: Status bit 3 is set when a word is taken while the synchronized INIT is low. It stays set until the next program pulse, which clears it.
- R8: Status bits 15:12 read VERSION (default 0x5). Bits 11:6 and bit 0 read 0.
- R9: Status bit 4 follows cfg_done_i after SYNC_STAGES clock edges.
- R10: Status bit 5 is set when the word taken equals 0xFF20. It is cleared by a program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_i | input | 1 | Request a program pulse (one cycle) |
| wr_i | input | 1 | Host write strobe for a configuration word |
| wdata_i | input | WORD_W | Configuration word, first byte in the upper half |
| status_o | output | 16 | Status word |
| cfg_prog_no | output | 1 | Target program line, active low |
| cfg_init_i | input | 1 | Target INIT line |
| cfg_done_i | input | 1 | Target DONE line |
| cfg_cclk_o | output | 1 | Configuration clock to target |
| cfg_din_o | output | 1 | Serial configuration data to target |

## Verification
The hardest case to reach is the error bit. It needs a loader that is still offering to take a word while the target's INIT line has already dropped. The bench completes a normal program pulse and INIT rise, then pulls INIT low during the ready window. It waits out the synchronizer and writes a word. It then confirms that the bit survives a later clean word and is cleared only by a new program pulse. A second hard case is an abort in the middle of a word, reached by issuing a program pulse partway through a transfer.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_UNCFG,
    ST_PROG,
    ST_WAIT_INIT,
    ST_READY,
    ST_SHIFT
  } ld_state_e;

  localparam int unsigned STAT_W = 16;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_prog_pulse.sv
module cfg_prog_pulse #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic end_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign end_o    = active_q && (cnt_q == '0) && !start_i;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= CNT_W'(CYCLES - 1);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cclk_o,
  output logic              din_o
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  left_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q, cclk_q;
  logic              tick;

  assign tick   = busy_q && (div_q == DIV_W'(CLK_DIV - 1));
  assign done_o = tick && cclk_q && (left_q == '0) && !abort_i;
  assign busy_o = busy_q;
  assign cclk_o = cclk_q;
  assign din_o  = busy_q ? sh_q[WORD_W-1] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      cclk_q <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cclk_q <= 1'b0;
      div_q  <= '0;
    end else if (start_i && !busy_q) begin
      sh_q   <= word_i;
      left_q <= BIT_W'(WORD_W - 1);
      div_q  <= '0;
      busy_q <= 1'b1;
      cclk_q <= 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          cclk_q <= 1'b0;
          if (left_q == '0) begin
            busy_q <= 1'b0;
          end else begin
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CLK_DIV     = 2,
  parameter int unsigned PROG_CYCLES = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  VERSION     = 4'h5,
  parameter logic [WORD_W-1:0] SYNC_WORD = WORD_W'(16'hFF20)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [15:0]       status_o,
  output logic              cfg_prog_no,
  input  logic              cfg_init_i,
  input  logic              cfg_done_i,
  output logic              cfg_cclk_o,
  output logic              cfg_din_o
);
  ld_state_e  state_q, state_d;
  logic [1:0] pins_s;
  logic       init_s, done_s;
  logic       pulse_active, pulse_end;
  logic       sh_busy, sh_done;
  logic       accept, txrdy;
  logic       err_q, sync_q;

  cfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_done_i, cfg_init_i}),
    .q_o   (pins_s)
  );
  assign init_s = pins_s[0];
  assign done_s = pins_s[1];

  cfg_prog_pulse #(.CYCLES(PROG_CYCLES)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_i),
    .active_o(pulse_active),
    .end_o   (pulse_end)
  );
  assign cfg_prog_no = !pulse_active;

  assign txrdy  = (state_q == ST_READY);
  assign accept = txrdy && wr_i && !prog_i;

  cfg_shifter #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .abort_i(prog_i),
    .word_i (wdata_i),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .cclk_o (cfg_cclk_o),
    .din_o  (cfg_din_o)
  );

  always_comb begin
    state_d = state_q;
    if (prog_i) begin
      state_d = ST_PROG;
    end else begin
      unique case (state_q)
        ST_UNCFG:     state_d = ST_UNCFG;
        ST_PROG:      if (pulse_end) state_d = ST_WAIT_INIT;
        ST_WAIT_INIT: if (init_s) state_d = ST_READY;
        ST_READY:     if (accept) state_d = ST_SHIFT;
        ST_SHIFT:     if (sh_done || !sh_busy) state_d = ST_READY;
        default:      state_d = ST_UNCFG;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNCFG;
      err_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (prog_i) begin
        err_q  <= 1'b0;
        sync_q <= 1'b0;
      end else if (accept) begin
        if (!init_s) err_q <= 1'b1;
        if (wdata_i == SYNC_WORD) sync_q <= 1'b1;
      end
    end
  end

  assign status_o = {VERSION, 6'b0, sync_q, done_s, err_q, txrdy, init_s, 1'b0};
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        prog_i,
  input logic        wr_i,
  input logic [15:0] status_o,
  input logic        cfg_prog_no,
  input logic        cfg_cclk_o,
  input logic        cfg_din_o
);
  assert_pulse_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> !cfg_prog_no);

  assert_no_ready_in_prog_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_prog_no |-> !status_o[2]);

  assert_idle_clock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> !cfg_cclk_o);

  assert_din_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_cclk_o && $past(cfg_cclk_o)) |-> $stable(cfg_din_o));

  assert_busy_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && status_o[2] && !prog_i) |=> !status_o[2]);

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !prog_i) |=> status_o[3]);

  assert_sync_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && !prog_i) |=> status_o[5]);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prog_i     (prog_i),
  .wr_i       (wr_i),
  .status_o   (status_o),
  .cfg_prog_no(cfg_prog_no),
  .cfg_cclk_o (cfg_cclk_o),
  .cfg_din_o  (cfg_din_o)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int W = 16, DIV = 2, PROG = 8, SYNC = 2;
  localparam int XFER = 2 * DIV * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog = 1'b0, wr = 1'b0, init = 1'b0, done = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [15:0] status;
  logic prog_n, cclk, din;
  int checks = 0, errors = 0;
  logic [W-1:0] cap = '0;
  int ncap = 0;

  always #5 clk = ~clk;

  cfg_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_i(prog), .wr_i(wr), .wdata_i(wdata),
    .status_o(status), .cfg_prog_no(prog_n), .cfg_init_i(init),
    .cfg_done_i(done), .cfg_cclk_o(cclk), .cfg_din_o(din)
  );

  always @(posedge cclk) begin
    cap = {cap[W-2:0], din};
    ncap++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_prog(output int low);
    @(negedge clk); prog = 1'b1; init = 1'b0;
    @(negedge clk); prog = 1'b0;
    low = 0;
    while (!prog_n) begin low++; @(negedge clk); end
  endtask

  task automatic bring_ready();
    init = 1'b1;
    cyc(SYNC);
    chk("R3 not ready before sync", 32'(status[2]), 0);
    cyc(1);
    chk("R3 ready after init", 32'(status[2]), 1);
  endtask

  // returns cycles with txready low after the write
  task automatic send(input logic [W-1:0] w, output int busy);
    @(negedge clk); wr = 1'b1; wdata = w;
    @(negedge clk); wr = 1'b0;
    busy = 0;
    while (!status[2] && busy < 10000) begin busy++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int low, busy, n0;
    logic [W-1:0] w;
    cyc(2); rst_n = 1'b1; cyc(1);
    // R1 / R8 reset state
    chk("R1 prog_n idle", 32'(prog_n), 1);
    chk("R1 cclk idle", 32'(cclk), 0);
    chk("R8 status reset", 32'(status), 32'h5000);

    // R3 init mirror; still not ready without program pulse (R1)
    init = 1'b1; cyc(SYNC - 1);
    chk("R3 init before sync", 32'(status[1]), 0);
    cyc(1);
    chk("R3 init synced", 32'(status[1]), 1);
    chk("R1 no ready unconfigured", 32'(status[2]), 0);
    // R6 write while not ready
    n0 = ncap;
    @(negedge clk); wr = 1'b1; wdata = 16'hFFFF; @(negedge clk); wr = 1'b0;
    cyc(XFER);
    chk("R6 ignored unconfigured write", 32'(ncap - n0), 0);

    // R2 pulse length
    do_prog(low);
    chk("R2 pulse length", 32'(low), PROG);
    cyc(10);
    chk("R3 waits for init", 32'(status[2]), 0);
    bring_ready();

    // R10 sync word, R4 R5 transfer
    n0 = ncap;
    send(16'hFF20, busy);
    chk("R5 busy length", 32'(busy), XFER);
    chk("R4 bits emitted", 32'(ncap - n0), W);
    chk("R4 sync word bits", 32'(cap), 32'hFF20);
    chk("R10 sync bit", 32'(status[5]), 1);
    chk("R7 no error", 32'(status[3]), 0);

    // R4 sweep: walking ones and fixed patterns
    for (int i = 0; i < W + 5; i++) begin
      case (i - W)
        0: w = 16'h0000;
        1: w = 16'hFFFF;
        2: w = 16'hA5A5;
        3: w = 16'h5A5A;
        4: w = 16'h1234;
        default: w = W'(1) << i;
      endcase
      n0 = ncap;
      send(w, busy);
      chk("R4 word bits", 32'(cap), 32'(w));
      chk("R5 busy length", 32'(busy), XFER);
      chk("R4 bit count", 32'(ncap - n0), W);
    end
    chk("R10 sync kept", 32'(status[5]), 1);

    // R6 write during transfer ignored
    n0 = ncap;
    @(negedge clk); wr = 1'b1; wdata = 16'hC3A1;
    @(negedge clk); wdata = 16'h0F0F;
    @(negedge clk); wr = 1'b0;
    busy = 2;
    while (!status[2]) begin busy++; @(negedge clk); end
    chk("R6 first word kept", 32'(cap), 32'hC3A1);
    chk("R6 single transfer", 32'(ncap - n0), W);
    chk("R6 busy unchanged", 32'(busy), XFER + 1);

    // R7 error: INIT drops while ready
    init = 1'b0; cyc(SYNC + 1);
    chk("R3 init low", 32'(status[1]), 0);
    chk("R7 still ready", 32'(status[2]), 1);
    send(16'h1111, busy);
    chk("R7 error set", 32'(status[3]), 1);
    init = 1'b1; cyc(SYNC + 1);
    send(16'h2222, busy);
    chk("R7 error sticky", 32'(status[3]), 1);
    do_prog(low);
    chk("R7 error cleared", 32'(status[3]), 0);
    chk("R10 sync cleared", 32'(status[5]), 0);
    bring_ready();

    // R2 abort mid-transfer
    n0 = ncap;
    @(negedge clk); wr = 1'b1; wdata = 16'hFFFF;
    @(negedge clk); wr = 1'b0;
    cyc(10);
    prog = 1'b1; init = 1'b0;
    @(negedge clk); prog = 1'b0;
    chk("R2 abort cclk low", 32'(cclk), 0);
    chk("R2 abort prog low", 32'(prog_n), 0);
    chk("R2 abort not ready", 32'(status[2]), 0);
    cyc(XFER);
    chk("R2 abort stops bits", 32'(ncap - n0 < W), 1);
    bring_ready();

    // R9 done mirror
    done = 1'b1; cyc(SYNC - 1);
    chk("R9 done before sync", 32'(status[4]), 0);
    cyc(1);
    chk("R9 done synced", 32'(status[4]), 1);
    chk("R8 version", 32'(status[15:12]), 5);
    chk("R8 reserved zero", 32'({status[11:6], status[0]}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule